// File: doc/BRIEF.md
# Strap-Setting Reset Pulse Sequencer

This block takes an attached switch device through its power-on reset by driving the device's reset line through three timed phases. The line is held high, then pulled low, then raised again. Before the line rises for the last time, the block drives fixed strap levels onto the serial clock and data lines, so the device latches its default configuration as it leaves reset. When the sequence ends, the block stops driving the clock and data lines. The reset line is left driven high.

The sequence starts on a one-cycle start pulse. When the `AUTO_START` parameter is set, it also starts once after system reset. A `rc_present` input says whether a reset line is wired on the board. When it is low, the block touches no line and reports completion at once. `busy` is high while the sequence runs. `done` pulses for one cycle when it finishes. Phase lengths are given in milliseconds. A prescaler parameter converts clock cycles to milliseconds.

Top module: `switch_rst_sequencer`

## Requirements
- R1: While `rst` is high and in the first cycle after it, all enables (`rc_oe`, `sk_oe`, `di_oe`) are 0 and `busy` and `done` are 0; `rc_o` reads 1.
- R2: A start from idle with `rc_present`=1 makes `busy`=1, `rc_oe`=1 and `rc_o`=1 from the next cycle, for exactly `HIGH1_MS`*`CYC_PER_MS` cycles.
- R3: The reset line is then driven low (`rc_oe`=1, `rc_o`=0) for exactly `LOW_MS`*`CYC_PER_MS` cycles, with `sk_oe`=`di_oe`=0.
- R4: Then follows one strap cycle in which the reset line stays low and the clock line (`sk_oe`=1, `sk_o`=`SK_STRAP`, default 1) and the data line (`di_oe`=1, `di_o`=`DI_STRAP`, default 0) are driven.
- R5: The reset line is then driven high for exactly `HIGH2_MS`*`CYC_PER_MS` cycles, with the strap levels of R4 still driven.
- R6: One release cycle follows, with `sk_oe`=`di_oe`=0 and `busy`=1. From then on `rc_oe`=1 and `rc_o`=1 hold until the next reset line phase or system reset.
- R7: In the cycle after the release cycle, `done`=1 and `busy`=0 for exactly one cycle. After that the block is idle with `done`=0.
- R8: A start with `rc_present`=0 gives `done`=1 in the next cycle. `busy` stays 0, and no enable changes from its previous value.
- R9: A start pulse while `busy`=1, or in the `done` cycle, is ignored: the timeline continues unchanged and no new sequence follows.
- R10: With `AUTO_START`=1, the sequence begins in the first cycle after `rst` falls, without a start pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run the sequence |
| rc_present | input | 1 | 1 when a reset line is wired to the device |
| rc_o | output | 1 | Level for the device reset line |
| rc_oe | output | 1 | Drive enable for the reset line |
| sk_o | output | 1 | Level for the serial clock line |
| sk_oe | output | 1 | Drive enable for the serial clock line |
| di_o | output | 1 | Level for the serial data line |
| di_oe | output | 1 | Drive enable for the serial data line |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every output is compared, cycle by cycle, against a timeline computed from the phase lengths for three kinds of run: one started by reset, one started by a pulse, and one with the reset line absent. Each phase boundary is therefore checked to the exact cycle, which catches off-by-one errors in the prescaler or the millisecond count. A start pulse injected in the middle of the low phase, and another in the completion cycle, must leave the timeline unchanged; this tells a correct busy guard apart from a restart. Runs with the line absent, both from reset and after a completed sequence, show that the skip path drives nothing and that the reset line stays driven high once a sequence has completed.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_RC_HI1  = 3'd1,
    PH_RC_LOW  = 3'd2,
    PH_STRAP   = 3'd3,
    PH_RC_HI2  = 3'd4,
    PH_RELEASE = 3'd5,
    PH_DONE    = 3'd6
  } phase_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic int unsigned bits_for(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/rstseq_ms_timer.sv
module rstseq_ms_timer #(
  parameter int unsigned CYC_PER_MS = 50000,
  parameter int unsigned MS_W       = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [MS_W-1:0] load_ms,
  output logic            expire
);

  localparam int unsigned PRE_W   = rstseq_pkg::bits_for(CYC_PER_MS);
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(CYC_PER_MS - 1);

  logic [PRE_W-1:0] pre_q;
  logic [MS_W-1:0]  ms_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else if (load) begin
      pre_q <= PRE_TOP;
      ms_q  <= load_ms;
    end else if (ms_q != '0) begin
      if (pre_q == '0) begin
        pre_q <= PRE_TOP;
        ms_q  <= ms_q - 1'b1;
      end else begin
        pre_q <= pre_q - 1'b1;
      end
    end
  end

  assign expire = (ms_q == MS_W'(1)) && (pre_q == '0);

endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
  import rstseq_pkg::*;
#(
  parameter int unsigned HIGH1_MS   = 20,
  parameter int unsigned LOW_MS     = 100,
  parameter int unsigned HIGH2_MS   = 30,
  parameter bit          AUTO_START = 1'b1,
  parameter int unsigned MS_W       = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            rc_present,
  input  logic            expire,
  output phase_e          phase_nxt,
  output logic            load,
  output logic [MS_W-1:0] load_ms
);

  phase_e phase_q;
  logic   boot_q;
  logic   go;

  assign go = start | boot_q;

  always_comb begin
    phase_nxt = phase_q;
    unique case (phase_q)
      PH_IDLE:    if (go) phase_nxt = rc_present ? PH_RC_HI1 : PH_DONE;
      PH_RC_HI1:  if (expire) phase_nxt = PH_RC_LOW;
      PH_RC_LOW:  if (expire) phase_nxt = PH_STRAP;
      PH_STRAP:   phase_nxt = PH_RC_HI2;
      PH_RC_HI2:  if (expire) phase_nxt = PH_RELEASE;
      PH_RELEASE: phase_nxt = PH_DONE;
      PH_DONE:    phase_nxt = PH_IDLE;
      default:    phase_nxt = PH_IDLE;
    endcase
  end

  always_comb begin
    load    = 1'b0;
    load_ms = '0;
    if (phase_nxt != phase_q) begin
      unique case (phase_nxt)
        PH_RC_HI1: begin load = 1'b1; load_ms = MS_W'(HIGH1_MS); end
        PH_RC_LOW: begin load = 1'b1; load_ms = MS_W'(LOW_MS);   end
        PH_RC_HI2: begin load = 1'b1; load_ms = MS_W'(HIGH2_MS); end
        default:   begin load = 1'b0; load_ms = '0;              end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      boot_q  <= AUTO_START;
    end else begin
      phase_q <= phase_nxt;
      if (phase_q == PH_IDLE) boot_q <= 1'b0;
    end
  end

endmodule

// File: rtl/rstseq_pins.sv
module rstseq_pins
  import rstseq_pkg::*;
#(
  parameter bit SK_STRAP = 1'b1,
  parameter bit DI_STRAP = 1'b0
) (
  input  logic   clk,
  input  logic   rst,
  input  phase_e phase_nxt,
  output logic   rc_o,
  output logic   rc_oe,
  output logic   sk_o,
  output logic   sk_oe,
  output logic   di_o,
  output logic   di_oe,
  output logic   busy,
  output logic   done
);

  logic in_seq_d, rc_low_d, strap_d, rc_oe_d;

  always_comb begin
    in_seq_d = (phase_nxt == PH_RC_HI1) || (phase_nxt == PH_RC_LOW) ||
               (phase_nxt == PH_STRAP)  || (phase_nxt == PH_RC_HI2) ||
               (phase_nxt == PH_RELEASE);
    rc_low_d = (phase_nxt == PH_RC_LOW) || (phase_nxt == PH_STRAP);
    strap_d  = (phase_nxt == PH_STRAP)  || (phase_nxt == PH_RC_HI2);
    rc_oe_d  = rc_oe | in_seq_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rc_o  <= 1'b1;
      rc_oe <= 1'b0;
      sk_o  <= 1'b0;
      sk_oe <= 1'b0;
      di_o  <= 1'b0;
      di_oe <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      rc_o  <= ~rc_low_d;
      rc_oe <= rc_oe_d;
      sk_o  <= strap_d ? SK_STRAP : 1'b0;
      sk_oe <= strap_d;
      di_o  <= strap_d ? DI_STRAP : 1'b0;
      di_oe <= strap_d;
      busy  <= in_seq_d;
      done  <= (phase_nxt == PH_DONE);
    end
  end

endmodule

// File: rtl/switch_rst_sequencer.sv
module switch_rst_sequencer #(
  parameter int unsigned CYC_PER_MS = 50000,
  parameter int unsigned HIGH1_MS   = 20,
  parameter int unsigned LOW_MS     = 100,
  parameter int unsigned HIGH2_MS   = 30,
  parameter bit          AUTO_START = 1'b1,
  parameter bit          SK_STRAP   = 1'b1,
  parameter bit          DI_STRAP   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic rc_present,
  output logic rc_o,
  output logic rc_oe,
  output logic sk_o,
  output logic sk_oe,
  output logic di_o,
  output logic di_oe,
  output logic busy,
  output logic done
);

  localparam int unsigned MS_MAX = rstseq_pkg::max3(HIGH1_MS, LOW_MS, HIGH2_MS);
  localparam int unsigned MS_W   = rstseq_pkg::bits_for(MS_MAX);

  rstseq_pkg::phase_e phase_nxt;
  logic               load, expire;
  logic [MS_W-1:0]    load_ms;

  rstseq_fsm #(
    .HIGH1_MS(HIGH1_MS), .LOW_MS(LOW_MS), .HIGH2_MS(HIGH2_MS),
    .AUTO_START(AUTO_START), .MS_W(MS_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .start(start), .rc_present(rc_present),
    .expire(expire), .phase_nxt(phase_nxt), .load(load), .load_ms(load_ms)
  );

  rstseq_ms_timer #(.CYC_PER_MS(CYC_PER_MS), .MS_W(MS_W)) u_timer (
    .clk(clk), .rst(rst), .load(load), .load_ms(load_ms), .expire(expire)
  );

  rstseq_pins #(.SK_STRAP(SK_STRAP), .DI_STRAP(DI_STRAP)) u_pins (
    .clk(clk), .rst(rst), .phase_nxt(phase_nxt),
    .rc_o(rc_o), .rc_oe(rc_oe), .sk_o(sk_o), .sk_oe(sk_oe),
    .di_o(di_o), .di_oe(di_oe), .busy(busy), .done(done)
  );

endmodule

// File: rtl/switch_rst_sequencer_chk.sv
module switch_rst_sequencer_chk #(
  parameter bit SK_STRAP = 1'b1,
  parameter bit DI_STRAP = 1'b0
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic rc_o,
  input logic rc_oe,
  input logic sk_o,
  input logic sk_oe,
  input logic di_o,
  input logic di_oe,
  input logic busy,
  input logic done
);

  AST_STRAP_NEEDS_RC: assert property (@(posedge clk) disable iff (rst)
    sk_oe |-> rc_oe);  // R4
  AST_STRAP_LEVELS: assert property (@(posedge clk) disable iff (rst)
    sk_oe |-> (sk_o == SK_STRAP && di_o == DI_STRAP));  // R4
  AST_STRAP_PAIRED: assert property (@(posedge clk) disable iff (rst)
    sk_oe == di_oe);  // R5
  AST_RC_LOW_IN_SEQ: assert property (@(posedge clk) disable iff (rst)
    (rc_oe && !rc_o) |-> busy);  // R3
  AST_RC_STAYS_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    rc_oe |=> rc_oe);  // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R7
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));  // R7
  AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);  // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));  // R9

endmodule

bind switch_rst_sequencer switch_rst_sequencer_chk #(
  .SK_STRAP(SK_STRAP), .DI_STRAP(DI_STRAP)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .rc_o(rc_o), .rc_oe(rc_oe),
  .sk_o(sk_o), .sk_oe(sk_oe), .di_o(di_o), .di_oe(di_oe),
  .busy(busy), .done(done)
);

// File: tb/sim_switch_rst_sequencer.sv
module sim_switch_rst_sequencer;

  localparam int CLK_P = 10;
  localparam int CPM   = 4;
  localparam int H1    = 20 * CPM;
  localparam int LO    = 100 * CPM;
  localparam int H2    = 30 * CPM;
  localparam int T_STRAP = H1 + LO;
  localparam int T_REL   = T_STRAP + 1 + H2;
  localparam int T_DONE  = T_REL + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic rc_present = 1'b1;
  logic rc_o, rc_oe, sk_o, sk_oe, di_o, di_oe, busy, done;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P / 2) clk = ~clk;

  switch_rst_sequencer #(.CYC_PER_MS(CPM), .AUTO_START(1'b1)) u0 (
    .clk(clk), .rst(rst), .start(start), .rc_present(rc_present),
    .rc_o(rc_o), .rc_oe(rc_oe), .sk_o(sk_o), .sk_oe(sk_oe),
    .di_o(di_o), .di_oe(di_oe), .busy(busy), .done(done)
  );

  // order: rc_oe rc_o sk_oe sk_o di_oe di_o busy done
  function automatic logic [7:0] outs();
    return {rc_oe, rc_o, sk_oe, sk_o, di_oe, di_o, busy, done};
  endfunction

  function automatic logic [7:0] exp_at(input int t);
    if (t < H1)           return 8'b11_00_00_10;
    else if (t < T_STRAP) return 8'b10_00_00_10;
    else if (t == T_STRAP) return 8'b10_11_10_10;
    else if (t < T_REL)   return 8'b11_11_10_10;
    else if (t == T_REL)  return 8'b11_00_00_10;
    else if (t == T_DONE) return 8'b11_00_00_01;
    else                  return 8'b11_00_00_00;
  endfunction

  function automatic string req_at(input int t);
    if (t < H1)            return "R2";
    else if (t < T_STRAP)  return "R3";
    else if (t == T_STRAP) return "R4";
    else if (t < T_REL)    return "R5";
    else if (t == T_REL)   return "R6";
    else if (t == T_DONE)  return "R7";
    else                   return "R9";
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Called at the negedge right after the edge that started the run.
  task automatic run_seq(input int inj_t, input string tag);
    for (int t = 0; t <= T_DONE + 1; t++) begin
      check(t == inj_t ? {"R9 ", tag} : {req_at(t), " ", tag}, outs(), exp_at(t));
      start = (t == inj_t);
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog R7 actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 in reset", outs(), 8'b01_00_00_00);
    // R10: boot run begins right after reset falls
    rst = 1'b0;
    @(negedge clk);
    run_seq(-1, "boot R10");
    // idle: reset line stays driven high (R6)
    repeat (3) @(negedge clk);
    check("R6 idle hold", outs(), 8'b11_00_00_00);
    // pulse run with start injected in the low phase (R9)
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    run_seq(H1 + 10, "pulse");
    // pulse run with start injected in the done cycle (R9)
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    run_seq(T_DONE, "done-cycle");
    @(negedge clk);
    check("R9 no restart", outs(), 8'b11_00_00_00);
    // R8: skip after a completed sequence
    rc_present = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8 skip done", outs(), 8'b11_00_00_01);
    @(negedge clk);
    check("R8 skip idle", outs(), 8'b11_00_00_00);
    // R8 + R10: boot with no reset line wired
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 second reset", outs(), 8'b01_00_00_00);
    rst = 1'b0;
    @(negedge clk);
    check("R8 boot skip done", outs(), 8'b01_00_00_01);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R8 boot skip idle", outs(), 8'b01_00_00_00);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule